// File: doc/BRIEF.md
# Legacy Processor Sideband Controller

This block drives the sideband lines that a PC-style I/O controller presents to its host processor. It combines three address-bit-20 masking sources into one mask output, turns a floating-point error from the processor into an internal interrupt-13 request and an ignore-error handshake, and stretches a one-cycle init request into a fixed-length processor init pulse. It also owns the byte-wide system control port at I/O address 92h, whose bit 1 is the software-controlled fast A20 source.

Every processor-facing output is open-drain and active-low at the pin. Inside the chip each one is modelled as a drive-low enable: 1 means the pad pulls the line low, and 0 means the line is released to its external pull-up. The floating-point error input is active-low and asynchronous, so it is resynchronised before any logic uses it. Register traffic arrives on a simple strobe bus with address, write data, write strobe and read strobe. The coprocessor-error reporting enable comes in as a single bit from a control register kept elsewhere.

Top module: `legacy_sideband_ctl`

## Requirements
- R1: `a20m_drv_o` is registered. It is 1 in the cycle after any one of `kbc_a20_gate_i`, `usb_a20_req_i` or bit 1 of the port-92h register is 1, and it is 0 in the cycle after all three are 0.
- R2: A write strobe with address 0x0092 loads the whole byte into the port-92h register. The register resets to 0x00. A read strobe with address 0x0092 returns the register on `io_rdata_o` in the next cycle. A read of any other address returns 0x00, and so does a cycle with no read strobe.
- R3: `fpu_err_n_i` is active-low and passes through two synchronizing flops. `irq13_o` is 1 exactly when the error, as seen after those flops, was active and `err_rpt_en_i` was 1 in the previous cycle. The latency from the pin is three clock edges.
- R4: If `err_rpt_en_i` is 1, a write strobe to address 0x00F0 while the synchronized error is active sets `ignne_drv_o` at the next edge.
- R5: Once set, `ignne_drv_o` stays 1 until the synchronized error goes inactive. It clears at the edge that follows. That is three edges after `fpu_err_n_i` rises.
- R6: A write to 0x00F0 while the synchronized error is inactive has no effect: `ignne_drv_o` stays 0.
- R7: While `err_rpt_en_i` is 0, `irq13_o` and `ignne_drv_o` are 0, and an ignore-error that is already held is cleared at the next edge.
- R8: A request on `init_req_i` while no pulse is running makes `init_drv_o` 1 for exactly 16 consecutive cycles, starting at the next edge.
- R9: A request that arrives while an init pulse is running is ignored and does not extend the pulse.
- R10: A synchronous, active-high `rst` clears all state, and every output reads 0 after the first edge with reset applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| kbc_a20_gate_i | input | 1 | A20 gate request from the keyboard controller |
| usb_a20_req_i | input | 1 | A20 request from USB legacy emulation |
| fpu_err_n_i | input | 1 | Processor floating-point error, active low, asynchronous |
| err_rpt_en_i | input | 1 | Coprocessor error reporting enable |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| init_req_i | input | 1 | Processor init request |
| io_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| a20m_drv_o | output | 1 | Drive-low enable for the A20 mask line |
| ignne_drv_o | output | 1 | Drive-low enable for the ignore-numeric-error line |
| init_drv_o | output | 1 | Drive-low enable for the processor init line |
| irq13_o | output | 1 | Internal interrupt-13 request to the interrupt controller |

## Verification
Each output comes from a flop that sits next to the port, so a wrong internal state reaches the pins quickly. A corrupted port-92h byte shows on the A20 mask one edge after the write and on read data one edge after a read. A stuck or shortened synchronizer chain moves `irq13_o` off its three-edge latency. An ignore-error flag that arms wrongly or fails to release differs from expectation at the edge after the F0h write, or at the third edge after the error pin rises. A mis-counted init counter changes the pulse length or lets a second request retrigger the pulse, and a per-cycle comparison exposes that within 17 cycles of the request.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int unsigned IO_ADDR_W = 16;
  localparam int unsigned IO_DATA_W = 8;

  typedef logic [IO_ADDR_W-1:0] io_addr_t;
  typedef logic [IO_DATA_W-1:0] io_data_t;

  typedef struct packed {
    logic     wr;
    logic     rd;
    io_addr_t addr;
    io_data_t data;
  } io_cmd_t;
endpackage

// File: rtl/sbc_sync.sv
module sbc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sbc_port_reg.sv
module sbc_port_reg
  import sbc_pkg::*;
#(
  parameter io_addr_t PORT_ADDR = 16'h0092,
  parameter io_data_t RST_VAL   = '0
) (
  input  logic     clk,
  input  logic     rst,
  input  io_cmd_t  cmd,
  output io_data_t value,
  output io_data_t rdata
);
  logic hit;
  assign hit = (cmd.addr == PORT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= RST_VAL;
      rdata <= '0;
    end else begin
      if (cmd.wr && hit) value <= cmd.data;
      rdata <= (cmd.rd && hit) ? value : '0;
    end
  end
endmodule

// File: rtl/sbc_coproc_err.sv
module sbc_coproc_err
  import sbc_pkg::*;
#(
  parameter io_addr_t ERR_PORT = 16'h00F0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  logic    err_act,
  input  io_cmd_t cmd,
  output logic    ignne,
  output logic    irq
);
  logic err_wr;
  assign err_wr = cmd.wr && (cmd.addr == ERR_PORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ignne <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= enable && err_act;
      if (!enable)
        ignne <= 1'b0;
      else if (!err_act)
        ignne <= 1'b0;
      else if (err_wr)
        ignne <= 1'b1;
    end
  end
endmodule

// File: rtl/sbc_init_pulse.sv
module sbc_init_pulse #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic pulse
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      left  <= '0;
    end else if (!pulse) begin
      if (req) begin
        pulse <= 1'b1;
        left  <= LAST;
      end
    end else if (left == '0) begin
      pulse <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/legacy_sideband_ctl.sv
module legacy_sideband_ctl
  import sbc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned INIT_CYCLES  = 16,
  parameter int unsigned FAST_A20_BIT = 1,
  parameter io_addr_t    SYS_PORT     = 16'h0092,
  parameter io_addr_t    ERR_PORT     = 16'h00F0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 kbc_a20_gate_i,
  input  logic                 usb_a20_req_i,
  input  logic                 fpu_err_n_i,
  input  logic                 err_rpt_en_i,
  input  logic [IO_ADDR_W-1:0] io_addr_i,
  input  logic [IO_DATA_W-1:0] io_wdata_i,
  input  logic                 io_wr_i,
  input  logic                 io_rd_i,
  input  logic                 init_req_i,
  output logic [IO_DATA_W-1:0] io_rdata_o,
  output logic                 a20m_drv_o,
  output logic                 ignne_drv_o,
  output logic                 init_drv_o,
  output logic                 irq13_o
);
  io_cmd_t  cmd;
  io_data_t sys_val;
  logic     err_sync_n;
  logic     err_act;

  assign cmd.wr   = io_wr_i;
  assign cmd.rd   = io_rd_i;
  assign cmd.addr = io_addr_i;
  assign cmd.data = io_wdata_i;

  sbc_port_reg #(.PORT_ADDR(SYS_PORT), .RST_VAL('0)) u_sys (
    .clk(clk), .rst(rst), .cmd(cmd), .value(sys_val), .rdata(io_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) a20m_drv_o <= 1'b0;
    else     a20m_drv_o <= kbc_a20_gate_i | usb_a20_req_i | sys_val[FAST_A20_BIT];
  end

  sbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_err_sync (
    .clk(clk), .rst(rst), .d(fpu_err_n_i), .q(err_sync_n)
  );
  assign err_act = ~err_sync_n;

  sbc_coproc_err #(.ERR_PORT(ERR_PORT)) u_err (
    .clk(clk), .rst(rst), .enable(err_rpt_en_i), .err_act(err_act),
    .cmd(cmd), .ignne(ignne_drv_o), .irq(irq13_o)
  );

  sbc_init_pulse #(.CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst(rst), .req(init_req_i), .pulse(init_drv_o)
  );
endmodule

// File: rtl/sbc_sva.sv
module sbc_sva #(
  parameter int unsigned INIT_CYCLES = 16,
  parameter logic [15:0] ERR_PORT    = 16'h00F0
) (
  input logic        clk,
  input logic        rst,
  input logic        kbc_a20_gate_i,
  input logic        usb_a20_req_i,
  input logic        err_rpt_en_i,
  input logic [15:0] io_addr_i,
  input logic        io_wr_i,
  input logic        init_req_i,
  input logic        a20m_drv_o,
  input logic        ignne_drv_o,
  input logic        init_drv_o,
  input logic        irq13_o
);
  localparam int unsigned RW = $clog2(INIT_CYCLES + 1) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)             run_len <= '0;
    else if (init_drv_o) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  a_r1_source_masks: assert property (@(posedge clk) disable iff (rst)
    (kbc_a20_gate_i || usb_a20_req_i) |=> a20m_drv_o);

  a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq13_o |-> $past(err_rpt_en_i));

  a_r6_ignne_rise_on_write: assert property (@(posedge clk) disable iff (rst)
    $rose(ignne_drv_o) |-> $past(io_wr_i && io_addr_i == ERR_PORT));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !err_rpt_en_i |=> (!ignne_drv_o && !irq13_o));

  a_r8_start_on_req: assert property (@(posedge clk) disable iff (rst)
    $rose(init_drv_o) |-> $past(init_req_i));

  a_r9_no_stretch: assert property (@(posedge clk) disable iff (rst)
    init_drv_o |-> (run_len < RW'(INIT_CYCLES)));

  a_r8_full_length: assert property (@(posedge clk) disable iff (rst)
    $fell(init_drv_o) |-> (run_len == RW'(INIT_CYCLES)));

  a_r10_reset_release: assert property (@(posedge clk)
    rst |=> (!a20m_drv_o && !ignne_drv_o && !init_drv_o && !irq13_o));
endmodule

bind legacy_sideband_ctl sbc_sva #(.INIT_CYCLES(INIT_CYCLES), .ERR_PORT(ERR_PORT)) u_sva (
  .clk(clk), .rst(rst), .kbc_a20_gate_i(kbc_a20_gate_i), .usb_a20_req_i(usb_a20_req_i),
  .err_rpt_en_i(err_rpt_en_i), .io_addr_i(io_addr_i), .io_wr_i(io_wr_i),
  .init_req_i(init_req_i), .a20m_drv_o(a20m_drv_o), .ignne_drv_o(ignne_drv_o),
  .init_drv_o(init_drv_o), .irq13_o(irq13_o)
);

// File: tb/sim_legacy_sideband_ctl.sv
`timescale 1ns/1ps
module sim_legacy_sideband_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kbc = 1'b0, usb = 1'b0, ferr_n = 1'b1, en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic wr = 1'b0, rd = 1'b0, ireq = 1'b0;
  logic [7:0] rdata;
  logic a20m, ignne, initd, irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit s1, s2, m_ign, m_irq, m_a20;
  int m_p92, m_rd, m_left;

  always #4 clk = ~clk;

  legacy_sideband_ctl u0 (
    .clk(clk), .rst(rst), .kbc_a20_gate_i(kbc), .usb_a20_req_i(usb),
    .fpu_err_n_i(ferr_n), .err_rpt_en_i(en), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_wr_i(wr), .io_rd_i(rd), .init_req_i(ireq), .io_rdata_o(rdata),
    .a20m_drv_o(a20m), .ignne_drv_o(ignne), .init_drv_o(initd), .irq13_o(irq)
  );

  always @(posedge clk) begin
    if (rst) begin
      s1 = 0; s2 = 0; m_ign = 0; m_irq = 0; m_a20 = 0;
      m_p92 = 0; m_rd = 0; m_left = 0;
    end else begin
      bit nign;
      nign = m_ign;
      if (!en || !s2) nign = 0;
      else if (wr && addr == 16'h00F0) nign = 1;
      m_ign = nign;
      m_irq = en && s2;
      m_a20 = kbc || usb || ((m_p92 >> 1) & 1);
      m_rd  = (rd && addr == 16'h0092) ? m_p92 : 0;
      if (wr && addr == 16'h0092) m_p92 = wdata;
      if (m_left == 0) begin
        if (ireq) m_left = 16;
      end else m_left = m_left - 1;
      s2 = s1;
      s1 = !ferr_n;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk("R1 a20m", a20m, m_a20);
      chk("R2 rdata", rdata, m_rd);
      chk("R3 irq13", irq, m_irq);
      chk("R4 ignne", ignne, m_ign);
      chk("R8 init", initd, (m_left != 0));
    end
    if (cyc > 5000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step(1);
    wr = 1'b0;
  endtask

  initial begin
    int n;
    step(4);
    chk("R10 reset a20m", a20m, 0);
    chk("R10 reset ignne", ignne, 0);
    chk("R10 reset init", initd, 0);
    chk("R10 reset irq", irq, 0);
    chk("R10 reset rdata", rdata, 0);
    rst = 1'b0;
    step(2);

    // R1 each source alone
    kbc = 1; step(1); chk("R1 gate", a20m, 1);
    kbc = 0; step(1); chk("R1 gate off", a20m, 0);
    usb = 1; step(1); chk("R1 usb", a20m, 1);
    usb = 0; step(1);
    io_write(16'h0092, 8'h02); step(1); chk("R1 fast bit", a20m, 1);
    // R2 readback
    addr = 16'h0092; rd = 1; step(1); rd = 0; chk("R2 read 92h", rdata, 8'h02);
    addr = 16'h0093; rd = 1; step(1); rd = 0; chk("R2 other addr", rdata, 0);
    io_write(16'h0092, 8'hFD); step(1); chk("R1 fast clear", a20m, 0);
    addr = 16'h0092; rd = 1; step(1); rd = 0; chk("R2 read FD", rdata, 8'hFD);
    io_write(16'h0092, 8'h00); step(2);

    // R6 write with no error
    en = 1; step(2);
    io_write(16'h00F0, 8'h00); step(1);
    chk("R6 no arm", ignne, 0);

    // R3 irq latency
    ferr_n = 0; step(2); chk("R3 not yet", irq, 0);
    step(1); chk("R3 irq", irq, 1);
    io_write(16'h00F1, 8'h00); chk("R4 wrong addr", ignne, 0);
    io_write(16'h00F0, 8'h00); chk("R4 armed", ignne, 1);
    step(5); chk("R5 held", ignne, 1);
    ferr_n = 1; step(2); chk("R5 still held", ignne, 1);
    step(1); chk("R5 released", ignne, 0);
    chk("R3 irq off", irq, 0);

    // R7 disable
    ferr_n = 0; step(3);
    io_write(16'h00F0, 8'h00); chk("R7 pre-arm", ignne, 1);
    en = 0; step(1); chk("R7 cleared", ignne, 0); chk("R7 irq", irq, 0);
    io_write(16'h00F0, 8'h00); step(1); chk("R7 no arm", ignne, 0);
    ferr_n = 1; step(4);

    // R8 single pulse
    ireq = 1; step(1); ireq = 0;
    n = 0;
    repeat (30) begin n += initd; step(1); end
    chk("R8 length", n, 16);

    // R9 request during pulse
    ireq = 1; step(1); ireq = 0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      n += initd;
      ireq = (i == 5 || i == 6 || i == 15);
      step(1);
    end
    ireq = 0;
    chk("R9 ignored", n, 16);

    // held request: back-to-back pulses
    ireq = 1; step(40); ireq = 0; step(20);
    chk("R9 idle after", initd, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule